// File: doc/BRIEF.md
# Interrupt Vector Offset Encoder

The block is a custom-instruction unit that sits beside a processor and takes over interrupt dispatch. Without it, software scans the pending bits in a loop. The instruction takes no operands. It reads the 32-bit pending-interrupt vector, which is already masked by the enable register, and returns one 32-bit word. Software can use that word directly as a byte offset into a table of 8-byte handler entries.

The lowest-numbered pending line has the highest priority, so line 0 beats every other line. When no line is pending, the result is the all-ones word. Its sign bit is set, so one signed test on the result tells software whether there is anything to dispatch.

The encoder is a two-level tree of small priority stages, not a serial chain. A parameter selects one of two variants:
- The combinational variant answers in the cycle of the request.
- The registered variant raises `done` one cycle after `start` and holds its result word between requests.

Top module: `irq_offset_enc`

## Requirements
- R1: When `pending` is zero, the result is 0xFFFFFFFF, so bit 31 is set.
- R2: When any bit of `pending` is set, the lowest-numbered set bit is the winner. Bit 0 has the highest priority, and higher set bits have no effect on the result.
- R3: A valid result equals the winning line number times 8: the line number sits in bits 7:3, and bits 2:0 and 31:8 are zero. The range is 0 to 248.
- R4: In the combinational variant (`REGISTERED`=0), `result` reflects the present `pending` in the same cycle, and `done` equals `start`.
- R5: In the registered variant (`REGISTERED`=1), `done` is high in exactly the cycle after each cycle in which `start` is high, and is low otherwise.
- R6: In the registered variant, `result` changes only in the cycle after a `start`. While `done` is high and at all other times, it holds the value captured from `pending` at that `start`.
- R7: In the registered variant, during and straight after reset, `done` is low and `result` is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the registered variant) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction request |
| pending | input | 32 | Masked pending-interrupt vector, one bit per line |
| result | output | 32 | Handler table byte offset, or all ones when nothing is pending |
| done | output | 1 | Result valid |

## Verification
A wrong priority stage in the tree picks a higher line or a wrong group. That shows up as an offset that is too large, in the same cycle for the combinational variant and one cycle after `start` for the registered one. A broken scaling stage shows up as nonzero low bits or as an offset above 248, and a broken empty detect shows up as a clear sign bit on a zero vector. A capture register that follows `pending` without a `start` shows up as a result that drifts in the cycle after `done` drops.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int unsigned MAX_W = 64;

  // Shift a line number left by the entry-size exponent to form a table offset.
  function automatic logic [MAX_W-1:0] scale_index(input logic [31:0] idx,
                                                   input int unsigned shift);
    return MAX_W'(idx) << shift;
  endfunction
endpackage

// File: rtl/irq_prio_leaf.sv
module irq_prio_leaf #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Small priority stage: the lowest set bit wins.
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_result_fmt.sv
module irq_result_fmt #(
  parameter int RES_W       = 32,
  parameter int IDX_W       = 5,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic             any,
  input  logic [IDX_W-1:0] idx,
  output logic [RES_W-1:0] res
);
  import irq_enc_pkg::*;

  logic [MAX_W-1:0] scaled;

  always_comb begin
    scaled = scale_index(32'(idx), ENTRY_SHIFT);
    res    = any ? scaled[RES_W-1:0] : '1;
  end
endmodule

// File: rtl/irq_offset_enc.sv
module irq_offset_enc #(
  parameter int LINES       = 32,
  parameter int GROUP_W     = 4,
  parameter int RES_W       = 32,
  parameter int ENTRY_SHIFT = 3,
  parameter bit REGISTERED  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LINES-1:0] pending,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam int NGROUPS = LINES / GROUP_W;
  localparam int SUB_W   = $clog2(GROUP_W);
  localparam int GRP_W   = $clog2(NGROUPS);
  localparam int IDX_W   = SUB_W + GRP_W;

  logic [NGROUPS-1:0] grp_any;
  logic [SUB_W-1:0]   grp_idx [NGROUPS];
  logic [GRP_W-1:0]   win_grp;
  logic               win_any;   // named event: some line pending
  logic [IDX_W-1:0]   win_idx;   // named event: winning line number
  logic [RES_W-1:0]   result_now;

  // First tree level: one priority stage per group of lines.
  for (genvar g = 0; g < NGROUPS; g++) begin : g_leaf
    irq_prio_leaf #(.W(GROUP_W), .IW(SUB_W)) u_leaf (
      .req (pending[g*GROUP_W +: GROUP_W]),
      .any (grp_any[g]),
      .idx (grp_idx[g])
    );
  end

  // Second tree level: pick the lowest group that has a pending line.
  irq_prio_leaf #(.W(NGROUPS), .IW(GRP_W)) u_root (
    .req (grp_any),
    .any (win_any),
    .idx (win_grp)
  );

  assign win_idx = {win_grp, grp_idx[win_grp]};

  irq_result_fmt #(.RES_W(RES_W), .IDX_W(IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_fmt (
    .any (win_any),
    .idx (win_idx),
    .res (result_now)
  );

  if (REGISTERED) begin : g_reg
    logic [RES_W-1:0] res_q;
    logic             done_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= '1;
        done_q <= 1'b0;
      end else begin
        done_q <= start;
        if (start) res_q <= result_now;
      end
    end
    assign result = res_q;
    assign done   = done_q;
  end else begin : g_comb
    assign result = result_now;
    assign done   = start;
  end
endmodule

// File: rtl/irq_offset_enc_chk.sv
module irq_offset_enc_chk #(
  parameter int LINES       = 32,
  parameter int RES_W       = 32,
  parameter int ENTRY_SHIFT = 3,
  parameter int IDX_W       = 5,
  parameter bit REGISTERED  = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LINES-1:0] pending,
  input logic [RES_W-1:0] result,
  input logic             done,
  input logic             win_any,
  input logic [IDX_W-1:0] win_idx
);
  p_any_matches_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_any == (pending != '0));

  p_winner_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> pending[win_idx]);

  p_no_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> ((pending & ((LINES'(1) << win_idx) - LINES'(1))) == '0));

  p_sentinel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[RES_W-1]) |-> (result == '1));

  p_offset_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result[RES_W-1]) |->
      (result[ENTRY_SHIFT-1:0] == '0 && (result >> ENTRY_SHIFT) < RES_W'(LINES)));

  if (REGISTERED) begin : g_reg_chk
    p_done_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
    p_done_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> $stable(result));
  end else begin : g_comb_chk
    p_comb_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done == start);
  end
endmodule

bind irq_offset_enc irq_offset_enc_chk #(
  .LINES(LINES), .RES_W(RES_W), .ENTRY_SHIFT(ENTRY_SHIFT),
  .IDX_W(IDX_W), .REGISTERED(REGISTERED)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pending(pending),
  .result(result), .done(done), .win_any(win_any), .win_idx(win_idx)
);

// File: tb/test_irq_offset_enc.sv
module test_irq_offset_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pending = '0;
  logic [31:0] res_r, res_c;
  logic        done_r, done_c;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_offset_enc #(.REGISTERED(1'b1)) i_irq_offset_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .pending(pending),
    .result(res_r), .done(done_r));

  irq_offset_enc #(.REGISTERED(1'b0)) i_irq_offset_enc_c (
    .clk(clk), .rst_n(rst_n), .start(start), .pending(pending),
    .result(res_c), .done(done_c));

  // Reference model: count trailing zeros, then scale by 8; empty -> all ones.
  function automatic logic [31:0] ref_offset(input logic [31:0] v);
    if (v == 32'd0) return 32'hFFFF_FFFF;
    for (int n = 0; n < 32; n++) begin
      if (v[n]) return 32'(n) * 32'd8;
    end
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Applies a vector, then checks both variants through request, done and hold.
  task automatic run_vec(input logic [31:0] v, input string req);
    logic [31:0] exp;
    exp = ref_offset(v);
    @(negedge clk);
    pending = v;
    start   = 1'b1;
    #1;
    chk({req, "/R4 comb result"}, res_c, exp);
    chk("R4 comb done", 32'(done_c), 32'd1);
    @(negedge clk);
    chk({req, "/R5 reg done"}, 32'(done_r), 32'd1);
    chk({req, "/R3 reg result"}, res_r, exp);
    start   = 1'b0;
    pending = $urandom;
    #1;
    chk("R4 comb done idle", 32'(done_c), 32'd0);
    @(negedge clk);
    chk("R5 reg done drop", 32'(done_r), 32'd0);
    chk("R6 reg hold", res_r, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R7 reset done", 32'(done_r), 32'd0);
    chk("R7 reset result", res_r, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after reset result", res_r, 32'hFFFF_FFFF);
    chk("R7 after reset done", 32'(done_r), 32'd0);

    run_vec(32'h0, "R1");
    for (int b = 0; b < 32; b++) run_vec(32'd1 << b, "R3");
    run_vec(32'hFFFF_FFFF, "R2");
    run_vec(32'h8000_0001, "R2");
    run_vec(32'hF000_0000, "R2");
    run_vec(32'h0, "R1");
    for (int k = 0; k < 120; k++) run_vec($urandom, "R2");
    for (int k = 0; k < 120; k++) run_vec($urandom & $urandom & $urandom & $urandom, "R2");

    // R6: pending changes with no start must leave the registered result alone.
    @(negedge clk);
    pending = 32'h0000_0100;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      pending = $urandom | 32'd1;
      @(negedge clk);
      chk("R6 idle hold", res_r, 32'd64);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule